// File: doc/BRIEF.md
# Dual-Width SEC-DED Memory EDAC

This block sits in the data path between a processor and a memory that stores a 16-bit data word together with a check field. It is purely combinational, so results appear in the same cycle as the inputs. On the write side it computes the check field from the outgoing 16-bit word. On the read side it takes the stored data and check bits, forms a syndrome, and returns the data along with a correctable-error flag and an uncorrectable-error flag. The raw syndrome is also driven out, so a host can analyse errors itself.

Two static inputs set how it behaves. The width select picks a 6-bit check field, giving a 22-bit stored word, or an 8-bit check field, giving a 24-bit stored word. The two widths use different fixed parity matrices. Each matrix has odd-weight columns, so single errors can be corrected and double errors detected. Each matrix also detects any error that stays within one memory device: an aligned 4-bit group in the narrow layout, or an aligned 8-bit group in the wide layout. The detect-only select turns off all automatic correction. This suits environments where a burst of many flipped bits can look like a single-bit error.

In the stored word, data bit i sits at position i (0 to 15) and check bit j sits at position 16+j.

Top module: `edac_flow`

## Requirements
- R1: When the read inputs equal a word and the check field the block generated for it, `syndrome` is zero, both flags are low and `rd_data_out` equals `rd_data`.
- R2: With `wide_chk`=0, `check_out[7:6]` is zero, `syndrome[7:6]` is zero, and `rd_check[7:6]` has no effect on any output.
- R3: In correcting mode (`detect_only`=0), flipping any single bit of the stored word makes `rd_data_out` equal the original data, with `err_corr`=1 and `err_unc`=0.
- R4: A single flip of stored check bit j (position 16+j) gives `syndrome` equal to a one-hot value with only bit j set.
- R5: Flipping any two distinct bits of the stored word gives `err_unc`=1 and `err_corr`=0, and `rd_data_out` equals the corrupted `rd_data`.
- R6: The syndrome of a two-bit error equals the XOR of the syndromes of the two single-bit errors.
- R7: With `wide_chk`=0, every nonzero error pattern confined to one aligned 4-bit group of the 22-bit stored word (positions 4k to 4k+3; the last group is 20 to 21) gives a nonzero syndrome and raises at least one flag.
- R8: With `wide_chk`=1, every nonzero error pattern confined to one aligned 8-bit group of the 24-bit stored word gives a nonzero syndrome and raises at least one flag.
- R9: With `detect_only`=1, any nonzero syndrome gives `err_unc`=1, `err_corr`=0 and `rd_data_out` equal to `rd_data`. A clean word raises no flag.
- R10: `err_corr` and `err_unc` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wide_chk | input | 1 | 1 selects the 8-bit check field, 0 selects the 6-bit field |
| detect_only | input | 1 | 1 disables correction; every error is reported as uncorrectable |
| wr_data | input | 16 | Data word being written to memory |
| check_out | output | 8 | Check field generated for `wr_data` (upper two bits zero in narrow mode) |
| rd_data | input | 16 | Data bits read from memory |
| rd_check | input | 8 | Check bits read from memory |
| rd_data_out | output | 16 | Read data, corrected when a correctable error was found |
| err_corr | output | 1 | A correctable single-bit error was found and handled |
| err_unc | output | 1 | An error was found and not corrected |
| syndrome | output | 8 | Raw syndrome of the read word |

## Verification
Some properties are checked whenever any input changes: the two flags are mutually exclusive, a zero syndrome means clean pass-through, an uncorrectable result returns the raw data, at most one data bit is ever inverted, an even-weight nonzero syndrome is always uncorrectable, detect-only mode never corrects, and the narrow-mode upper lanes stay zero. Other properties depend on the particular matrices chosen, and only the bench scenarios can show them. These are that every single error is repaired, every double error is caught, syndromes combine linearly, and every error inside an aligned device group is detected. The bench shows these by exhaustive injection over all positions, pairs and group patterns on random data, in both widths.

// File: rtl/edac_pkg.sv
`timescale 1ns/1ps
package edac_pkg;

    localparam int DATA_W      = 16;
    localparam int CHK_W       = 8;
    localparam int CHK_NARROW  = 6;
    localparam int HALF_W      = DATA_W / 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef struct packed {
        data_t data;
        logic  corr;
        logic  unc;
    } rd_result_t;

    // Lane mask for the active check field.
    function automatic syn_t lane_mask(input logic wide);
        lane_mask = wide ? '1 : syn_t'((1 << CHK_NARROW) - 1);
    endfunction

    // Column of the parity matrix for data bit idx.
    // Narrow: weight-3 columns, four per nibble, each nibble independent.
    // Wide: byte 0 uses rotations of a weight-3 seed, byte 1 rotations of a
    // weight-5 seed; both circulants are invertible, so each byte is independent.
    function automatic syn_t h_col(input logic wide, input int unsigned idx);
        logic [CHK_NARROW-1:0] n;
        logic [CHK_W-1:0]      seed;
        int unsigned           r;
        n = '0;
        case (idx)
            0:  n = 6'b000111;
            1:  n = 6'b001011;
            2:  n = 6'b010011;
            3:  n = 6'b100011;
            4:  n = 6'b011100;
            5:  n = 6'b101100;
            6:  n = 6'b001101;
            7:  n = 6'b001110;
            8:  n = 6'b110001;
            9:  n = 6'b110010;
            10: n = 6'b110100;
            11: n = 6'b111000;
            12: n = 6'b010101;
            13: n = 6'b011001;
            14: n = 6'b010110;
            15: n = 6'b101010;
            default: n = '0;
        endcase
        seed = (idx < HALF_W) ? 8'b0000_0111 : 8'b0001_1111;
        r    = idx % CHK_W;
        if (wide)
            h_col = syn_t'((seed << r) | (seed >> (CHK_W - r)));
        else
            h_col = syn_t'(n);
    endfunction

endpackage

// File: rtl/edac_encoder.sv
`timescale 1ns/1ps
module edac_encoder
    import edac_pkg::*;
(
    input  logic  wide,
    input  data_t data,
    output syn_t  chk
);
    syn_t acc_d;

    always_comb begin
        acc_d = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data[i])
                acc_d = acc_d ^ h_col(wide, i);
        end
        chk = acc_d & lane_mask(wide);
    end
endmodule

// File: rtl/edac_syndrome.sv
`timescale 1ns/1ps
module edac_syndrome
    import edac_pkg::*;
(
    input  logic  wide,
    input  data_t data,
    input  syn_t  stored_chk,
    output syn_t  syn
);
    syn_t recomputed;

    edac_encoder u_recalc (
        .wide (wide),
        .data (data),
        .chk  (recomputed)
    );

    always_comb begin
        syn = (recomputed ^ stored_chk) & lane_mask(wide);
    end
endmodule

// File: rtl/edac_locator.sv
`timescale 1ns/1ps
module edac_locator
    import edac_pkg::*;
(
    input  logic  wide,
    input  syn_t  syn,
    output data_t flip,
    output logic  chk_hit
);
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_col
            assign flip[gi] = (syn == h_col(wide, gi));
        end
    endgenerate

    always_comb begin
        chk_hit = $onehot(syn) && ((syn & ~lane_mask(wide)) == '0);
    end
endmodule

// File: rtl/edac_flow.sv
`timescale 1ns/1ps
module edac_flow
    import edac_pkg::*;
(
    input  logic        wide_chk,
    input  logic        detect_only,
    input  logic [15:0] wr_data,
    output logic [7:0]  check_out,
    input  logic [15:0] rd_data,
    input  logic [7:0]  rd_check,
    output logic [15:0] rd_data_out,
    output logic        err_corr,
    output logic        err_unc,
    output logic [7:0]  syndrome
);
    syn_t       syn_w;
    data_t      flip_w;
    logic       chk_hit_w;
    rd_result_t res_d;

    edac_encoder u_gen (
        .wide (wide_chk),
        .data (wr_data),
        .chk  (check_out)
    );

    edac_syndrome u_syn (
        .wide       (wide_chk),
        .data       (rd_data),
        .stored_chk (rd_check),
        .syn        (syn_w)
    );

    edac_locator u_loc (
        .wide    (wide_chk),
        .syn     (syn_w),
        .flip    (flip_w),
        .chk_hit (chk_hit_w)
    );

    always_comb begin
        res_d.data = rd_data;
        res_d.corr = 1'b0;
        res_d.unc  = 1'b0;
        if (syn_w != '0) begin
            if (detect_only) begin
                res_d.unc = 1'b1;
            end else if (flip_w != '0) begin
                res_d.data = rd_data ^ flip_w;
                res_d.corr = 1'b1;
            end else if (chk_hit_w) begin
                res_d.corr = 1'b1;
            end else begin
                res_d.unc = 1'b1;
            end
        end
    end

    assign rd_data_out = res_d.data;
    assign err_corr    = res_d.corr;
    assign err_unc     = res_d.unc;
    assign syndrome    = syn_w;
endmodule

// File: rtl/edac_flow_chk.sv
`timescale 1ns/1ps
module edac_flow_chk (
    input logic        wide_chk,
    input logic        detect_only,
    input logic [7:0]  check_out,
    input logic [15:0] rd_data,
    input logic [15:0] rd_data_out,
    input logic        err_corr,
    input logic        err_unc,
    input logic [7:0]  syndrome
);
    always_comb begin
        a_r10_flags_exclusive: assert (!(err_corr && err_unc))
            else $error("R10: both flags high");
        a_r1_clean_passthrough: assert (syndrome != 8'h00 ||
                (!err_corr && !err_unc && rd_data_out == rd_data))
            else $error("R1: clean word altered or flagged");
        a_r5_unc_raw: assert (!err_unc || rd_data_out == rd_data)
            else $error("R5: uncorrectable result changed data");
        a_r9_no_corr_detect: assert (!detect_only || !err_corr)
            else $error("R9: correction in detect-only mode");
        a_r9_error_flagged: assert (syndrome == 8'h00 || err_corr || err_unc)
            else $error("R9: nonzero syndrome without flag");
        a_r3_single_flip: assert ($countones(rd_data_out ^ rd_data) <= 1)
            else $error("R3: more than one bit inverted");
        a_r5_even_unc: assert (syndrome == 8'h00 || (^syndrome) || err_unc)
            else $error("R5: even syndrome not uncorrectable");
        a_r2_narrow_lanes: assert (wide_chk ||
                (check_out[7:6] == 2'b00 && syndrome[7:6] == 2'b00))
            else $error("R2: upper lanes active in narrow mode");
    end
endmodule

bind edac_flow edac_flow_chk u_chk (
    .wide_chk    (wide_chk),
    .detect_only (detect_only),
    .check_out   (check_out),
    .rd_data     (rd_data),
    .rd_data_out (rd_data_out),
    .err_corr    (err_corr),
    .err_unc     (err_unc),
    .syndrome    (syndrome)
);

// File: tb/edac_flow_bench.sv
`timescale 1ns/1ps
module edac_flow_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_chk = 1'b0;
    logic        detect_only = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  check_out;
    logic [15:0] rd_data = '0;
    logic [7:0]  rd_check = '0;
    logic [15:0] rd_data_out;
    logic        err_corr;
    logic        err_unc;
    logic [7:0]  syndrome;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [7:0] single_syn [24];

    always #5 clk = ~clk;

    edac_flow u_edac_flow (
        .wide_chk    (wide_chk),
        .detect_only (detect_only),
        .wr_data     (wr_data),
        .check_out   (check_out),
        .rd_data     (rd_data),
        .rd_check    (rd_check),
        .rd_data_out (rd_data_out),
        .err_corr    (err_corr),
        .err_unc     (err_unc),
        .syndrome    (syndrome)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after a rising edge, let it settle to the falling edge.
    task automatic drive(input logic [15:0] wd, input logic [15:0] rd, input logic [7:0] rc);
        @(posedge clk);
        wr_data  = wd;
        rd_data  = rd;
        rd_check = rc;
        @(negedge clk);
    endtask

    // Encode d, then present the stored word with error mask e on the read side.
    task automatic inject(input logic [15:0] d, input logic [23:0] e, output logic [7:0] chk);
        drive(d, d, 8'h00);
        chk = check_out;
        drive(d, d ^ e[15:0], chk ^ e[23:16]);
    endtask

    function automatic int nbits(input logic wide);
        return wide ? 24 : 22;
    endfunction

    task automatic run_mode(input logic wide);
        logic [7:0]  chk;
        logic [15:0] d;
        logic [23:0] e;
        int gsz;
        wide_chk    = wide;
        detect_only = 1'b0;

        // R1 / R2: clean round trips on random data
        for (int t = 0; t < 40; t++) begin
            d = 16'($urandom);
            drive(d, d, 8'h00);
            chk = check_out;
            check("R2 check_out upper lanes", {30'd0, chk[7:6]}, wide ? {30'd0, chk[7:6]} : 32'd0);
            if (!wide) chk[7:6] = 2'($urandom);
            drive(d, d, chk);
            check("R1 clean syndrome", {24'd0, syndrome}, 32'd0);
            check("R1 clean flags", {30'd0, err_corr, err_unc}, 32'd0);
            check("R1 clean data", {16'd0, rd_data_out}, {16'd0, d});
        end

        // R3 / R4: every single error
        for (int k = 0; k < nbits(wide); k++) begin
            d = 16'($urandom);
            e = 24'd1 << k;
            inject(d, e, chk);
            single_syn[k] = syndrome;
            check("R3 single corrected data", {16'd0, rd_data_out}, {16'd0, d});
            check("R3 single flags", {30'd0, err_corr, err_unc}, 32'd2);
            if (k >= 16)
                check("R4 check-bit syndrome", {24'd0, syndrome}, 32'd1 << (k - 16));
        end

        // R5 / R6: every double error
        for (int a = 0; a < nbits(wide); a++) begin
            for (int b = a + 1; b < nbits(wide); b++) begin
                d = 16'($urandom);
                e = (24'd1 << a) | (24'd1 << b);
                inject(d, e, chk);
                check("R5 double flags", {30'd0, err_corr, err_unc}, 32'd1);
                check("R5 double raw data", {16'd0, rd_data_out}, {16'd0, d ^ e[15:0]});
                check("R6 syndrome linearity", {24'd0, syndrome},
                      {24'd0, single_syn[a] ^ single_syn[b]});
            end
        end

        // R7 / R8: every pattern within an aligned device group
        gsz = wide ? 8 : 4;
        for (int s = 0; s < nbits(wide); s += gsz) begin
            int w;
            w = (nbits(wide) - s < gsz) ? nbits(wide) - s : gsz;
            for (int m = 1; m < (1 << w); m++) begin
                d = 16'($urandom);
                e = 24'(m) << s;
                inject(d, e, chk);
                check(wide ? "R8 byte group detected" : "R7 nibble group detected",
                      {31'd0, (syndrome != 8'h00) && (err_corr || err_unc)}, 32'd1);
            end
        end

        // R9: detect-only mode
        detect_only = 1'b1;
        d = 16'($urandom);
        inject(d, 24'd0, chk);
        check("R9 clean in detect-only", {30'd0, err_corr, err_unc}, 32'd0);
        for (int k = 0; k < nbits(wide); k++) begin
            d = 16'($urandom);
            e = 24'd1 << k;
            inject(d, e, chk);
            check("R9 single uncorrected flags", {30'd0, err_corr, err_unc}, 32'd1);
            check("R9 single raw data", {16'd0, rd_data_out}, {16'd0, d ^ e[15:0]});
        end
        for (int t = 0; t < 30; t++) begin
            d = 16'($urandom);
            e = 24'($urandom) & (wide ? 24'hFFFFFF : 24'h3FFFFF);
            inject(d, e, chk);
            if (syndrome != 8'h00) begin
                check("R9 random error flags", {30'd0, err_corr, err_unc}, 32'd1);
                check("R9 random raw data", {16'd0, rd_data_out}, {16'd0, d ^ e[15:0]});
            end
            check("R10 flags exclusive", {31'd0, err_corr && err_unc}, 32'd0);
        end
        detect_only = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle zero word syndrome", {24'd0, syndrome}, 32'd0);
        check("R1 idle zero word flags", {30'd0, err_corr, err_unc}, 32'd0);
        run_mode(1'b0);
        run_mode(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule